// File: doc/BRIEF.md
# Forward-State Snooping Line Coherence Controller

This block keeps the coherence state of every line in one private cache. The cache sits on a snooping bus. Each line is in one of five states: Invalid, Shared, Exclusive, Forward or Modified. Forward marks the one cache that owns a clean line held by several caches. That cache answers bus reads in place of memory. Ownership of a clean shared line always passes to the cache that read it most recently. A small state array holds one entry per line index.

The processor side presents read, write and evict requests. In the same cycle the block drives the bus transaction that the request needs: a read, a read-with-intent-to-modify, or an invalidate. On a read miss it samples the wired shared line, which tells it whether any other cache holds a copy. The snoop side presents the bus transactions of other caches. The block answers them with a data-supply strobe, a shared-line assertion and a write-back request, and updates the line state. Data storage, bus arbitration and memory are outside the block. Every bus request is taken as granted in the cycle it is issued.

Top module: `fwd_line_ctrl`

## Requirements
- R1: While reset is low, and directly after reset, every entry reads as Invalid on `line_state_o`. The state codes are I=0, S=1, E=2, F=3 and M=4.
- R2: A processor read (`cpu_op_i`=1) that misses issues a bus read (`bus_req_o`=1) in the same cycle. The line is installed as Forward if `shared_i` is high and as Exclusive if it is low. A read hit issues no bus request and leaves the state unchanged.
- R3: A snooped bus read (`snp_op_i`=1) that hits a Forward or Exclusive line raises `supply_o` and `shared_o` and demotes the line to Shared, without a write-back.
- R4: A snooped bus read that hits a Modified line raises `supply_o`, `shared_o` and `wb_o`, and the line becomes Shared.
- R5: A snooped bus read that hits a Shared line raises only `shared_o`, and the line stays Shared. A snooped bus read on an Invalid line raises no output and leaves the line Invalid.
- R6: A processor write (`cpu_op_i`=2) that hits a Shared or Forward line issues a bus invalidate (`bus_req_o`=3), and the line becomes Modified. A write that hits an Exclusive line, or a Modified line, issues no bus request, and the line ends as Modified.
- R7: A processor write that misses issues read-with-intent-to-modify (`bus_req_o`=2), and the line is installed as Modified.
- R8: A snooped read-with-intent-to-modify (`snp_op_i`=2) or invalidate (`snp_op_i`=3) leaves the line Invalid. Read-with-intent-to-modify that hits a Modified line also raises `supply_o`, with no write-back. No other snooped case raises `supply_o`.
- R9: A processor evict (`cpu_op_i`=3) leaves the line Invalid. `wb_o` is raised only when the line was Modified. Evicting any other state issues no bus request.
- R10: If a snoop and a processor request target the same index in one cycle, the snoop is applied first. The processor request is then judged against the state the snoop produced, and its result is what the entry keeps. Requests to different indices in one cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_op_i | input | 2 | Processor request: 0 idle, 1 read, 2 write, 3 evict |
| cpu_idx_i | input | IDX_W | Line index of the processor request |
| shared_i | input | 1 | Wired shared line from the other caches, sampled on a read miss |
| snp_op_i | input | 2 | Snooped transaction: 0 none, 1 read, 2 read-with-intent-to-modify, 3 invalidate |
| snp_idx_i | input | IDX_W | Line index of the snooped transaction |
| bus_req_o | output | 2 | Bus transaction issued: 0 none, 1 read, 2 read-with-intent-to-modify, 3 invalidate |
| supply_o | output | 1 | This cache supplies the snooped line |
| shared_o | output | 1 | This cache asserts the shared line |
| wb_o | output | 1 | Write-back of a modified line to memory |
| line_state_o | output | 3 | Current state of the entry at `cpu_idx_i` |

## Verification
`bus_req_o`, `supply_o`, `shared_o` and `wb_o` respond combinationally in the cycle the request is presented. The bench samples them 1 ns after it drives the inputs, which is before the next rising edge. A state change becomes visible on `line_state_o` once the rising edge has passed. The bench reads it in a later idle cycle by pointing `cpu_idx_i` at the entry. Every reachable state is swept against every snoop kind and against every processor request, with both shared-line levels. Same-index collisions are checked by their bus request in the same cycle and by the state that results.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [2:0] {
    ST_I = 3'd0,
    ST_S = 3'd1,
    ST_E = 3'd2,
    ST_F = 3'd3,
    ST_M = 3'd4
  } line_st_e;

  typedef enum logic [1:0] {
    CPU_IDLE  = 2'd0,
    CPU_RD    = 2'd1,
    CPU_WR    = 2'd2,
    CPU_EVICT = 2'd3
  } cpu_op_e;

  typedef enum logic [1:0] {
    BUS_NONE  = 2'd0,
    BUS_RD    = 2'd1,
    BUS_RWITM = 2'd2,
    BUS_INV   = 2'd3
  } bus_op_e;

  typedef struct packed {
    logic     we;
    line_st_e nxt;
    logic     supply;
    logic     share;
    logic     wb;
  } snp_res_t;

  typedef struct packed {
    logic     we;
    line_st_e nxt;
    bus_op_e  req;
    logic     wb;
  } cpu_res_t;
endpackage

// File: rtl/fwd_snoop_resp.sv
module fwd_snoop_resp
  import fwd_pkg::*;
(
  input  line_st_e cur_i,
  input  bus_op_e  op_i,
  output snp_res_t res_o
);
  always_comb begin
    res_o        = '0;
    res_o.nxt    = cur_i;
    unique case (op_i)
      BUS_RD: begin
        if (cur_i != ST_I) begin
          res_o.we    = 1'b1;
          res_o.nxt   = ST_S;
          res_o.share = 1'b1;
          // owners hand data over; ownership goes to requester
          res_o.supply = (cur_i == ST_F) || (cur_i == ST_E) || (cur_i == ST_M);
          res_o.wb     = (cur_i == ST_M);
        end
      end
      BUS_RWITM: begin
        res_o.we     = 1'b1;
        res_o.nxt    = ST_I;
        res_o.supply = (cur_i == ST_M);
      end
      BUS_INV: begin
        res_o.we  = 1'b1;
        res_o.nxt = ST_I;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fwd_cpu_resp.sv
module fwd_cpu_resp
  import fwd_pkg::*;
(
  input  line_st_e cur_i,
  input  cpu_op_e  op_i,
  input  logic     shared_i,
  output cpu_res_t res_o
);
  always_comb begin
    res_o     = '0;
    res_o.nxt = cur_i;
    res_o.req = BUS_NONE;
    unique case (op_i)
      CPU_RD: begin
        if (cur_i == ST_I) begin
          res_o.we  = 1'b1;
          res_o.req = BUS_RD;
          res_o.nxt = shared_i ? ST_F : ST_E;
        end
      end
      CPU_WR: begin
        res_o.we  = 1'b1;
        res_o.nxt = ST_M;
        unique case (cur_i)
          ST_I:       res_o.req = BUS_RWITM;
          ST_S, ST_F: res_o.req = BUS_INV;
          default:    res_o.req = BUS_NONE;
        endcase
      end
      CPU_EVICT: begin
        res_o.we  = 1'b1;
        res_o.nxt = ST_I;
        res_o.wb  = (cur_i == ST_M);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fwd_state_array.sv
module fwd_state_array
  import fwd_pkg::*;
#(
  parameter int IDX_W = 3,
  localparam int N = 1 << IDX_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 snp_we_i,
  input  logic [IDX_W-1:0]     snp_idx_i,
  input  line_st_e             snp_nxt_i,
  input  logic                 cpu_we_i,
  input  logic [IDX_W-1:0]     cpu_idx_i,
  input  line_st_e             cpu_nxt_i,
  output line_st_e [N-1:0]     st_q_o
);
  for (genvar g = 0; g < N; g++) begin : g_entry
    logic cpu_hit, snp_hit;
    assign cpu_hit = cpu_we_i && (cpu_idx_i == IDX_W'(g));
    assign snp_hit = snp_we_i && (snp_idx_i == IDX_W'(g));
    // cpu result already includes any same-index snoop
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      st_q_o[g] <= ST_I;
      else if (cpu_hit) st_q_o[g] <= cpu_nxt_i;
      else if (snp_hit) st_q_o[g] <= snp_nxt_i;
    end
  end
endmodule

// File: rtl/fwd_line_ctrl.sv
module fwd_line_ctrl
  import fwd_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       cpu_op_i,
  input  logic [IDX_W-1:0] cpu_idx_i,
  input  logic             shared_i,
  input  logic [1:0]       snp_op_i,
  input  logic [IDX_W-1:0] snp_idx_i,
  output logic [1:0]       bus_req_o,
  output logic             supply_o,
  output logic             shared_o,
  output logic             wb_o,
  output logic [2:0]       line_state_o
);
  localparam int N = 1 << IDX_W;

  line_st_e [N-1:0] st_q;
  snp_res_t         snp_res;
  cpu_res_t         cpu_res;
  line_st_e         cpu_view;
  logic             collide;

  fwd_snoop_resp i_snoop (
    .cur_i (st_q[snp_idx_i]),
    .op_i  (bus_op_e'(snp_op_i)),
    .res_o (snp_res)
  );

  assign collide  = (bus_op_e'(snp_op_i) != BUS_NONE) && (snp_idx_i == cpu_idx_i);
  assign cpu_view = collide ? snp_res.nxt : st_q[cpu_idx_i];

  fwd_cpu_resp i_cpu (
    .cur_i    (cpu_view),
    .op_i     (cpu_op_e'(cpu_op_i)),
    .shared_i (shared_i),
    .res_o    (cpu_res)
  );

  fwd_state_array #(.IDX_W(IDX_W)) i_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .snp_we_i  (snp_res.we),
    .snp_idx_i (snp_idx_i),
    .snp_nxt_i (snp_res.nxt),
    .cpu_we_i  (cpu_res.we),
    .cpu_idx_i (cpu_idx_i),
    .cpu_nxt_i (cpu_res.nxt),
    .st_q_o    (st_q)
  );

  assign bus_req_o    = cpu_res.req;
  assign supply_o     = snp_res.supply;
  assign shared_o     = snp_res.share;
  assign wb_o         = snp_res.wb | cpu_res.wb;
  assign line_state_o = st_q[cpu_idx_i];
endmodule

// File: rtl/fwd_line_ctrl_chk.sv
module fwd_line_ctrl_chk
  import fwd_pkg::*;
#(
  parameter int IDX_W = 3,
  localparam int N = 1 << IDX_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       cpu_op_i,
  input logic [IDX_W-1:0] cpu_idx_i,
  input logic             shared_i,
  input logic [1:0]       snp_op_i,
  input logic [IDX_W-1:0] snp_idx_i,
  input logic [1:0]       bus_req_o,
  input logic             supply_o,
  input logic             shared_o,
  input logic             wb_o,
  input line_st_e [N-1:0] st_q
);
  logic same_idx;
  assign same_idx = (cpu_op_i != 2'd0) && (cpu_idx_i == snp_idx_i);

  assert_excl_install_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o == 2'd1 && !shared_i) |=> st_q[$past(cpu_idx_i)] == ST_E);

  assert_supply_source_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    supply_o |-> (snp_op_i == 2'd1 || snp_op_i == 2'd2));

  assert_mod_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_op_i == 2'd1 && st_q[snp_idx_i] == ST_M && !same_idx)
      |-> (wb_o && supply_o) ##1 st_q[$past(snp_idx_i)] == ST_S);

  assert_shared_on_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shared_o |-> snp_op_i == 2'd1);

  assert_inv_to_mod_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o == 2'd3) |=> st_q[$past(cpu_idx_i)] == ST_M);

  assert_rwitm_to_mod_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o == 2'd2) |=> st_q[$past(cpu_idx_i)] == ST_M);

  assert_snoop_kill_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((snp_op_i == 2'd2 || snp_op_i == 2'd3) && !same_idx)
      |=> st_q[$past(snp_idx_i)] == ST_I);

  assert_evict_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_op_i == 2'd3) |=> st_q[$past(cpu_idx_i)] == ST_I);

  assert_wb_source_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_o |-> (cpu_op_i == 2'd3 || snp_op_i == 2'd1));
endmodule

bind fwd_line_ctrl fwd_line_ctrl_chk #(.IDX_W(IDX_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cpu_op_i  (cpu_op_i),
  .cpu_idx_i (cpu_idx_i),
  .shared_i  (shared_i),
  .snp_op_i  (snp_op_i),
  .snp_idx_i (snp_idx_i),
  .bus_req_o (bus_req_o),
  .supply_o  (supply_o),
  .shared_o  (shared_o),
  .wb_o      (wb_o),
  .st_q      (st_q)
);

// File: tb/test_fwd_line_ctrl.sv
`timescale 1ns/1ps
module test_fwd_line_ctrl;
  localparam int IDX_W = 3;
  localparam int N = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] cpu_op = 2'd0;
  logic [IDX_W-1:0] cpu_idx = '0;
  logic shared_in = 1'b0;
  logic [1:0] snp_op = 2'd0;
  logic [IDX_W-1:0] snp_idx = '0;
  logic [1:0] bus_req_o;
  logic supply_o, shared_o, wb_o;
  logic [2:0] line_state_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [1:0] o_bus;
  logic o_sup, o_shr, o_wb;

  always #2 clk = ~clk;

  fwd_line_ctrl #(.IDX_W(IDX_W)) i_fwd_line_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .cpu_op_i(cpu_op), .cpu_idx_i(cpu_idx),
    .shared_i(shared_in), .snp_op_i(snp_op), .snp_idx_i(snp_idx),
    .bus_req_o(bus_req_o), .supply_o(supply_o), .shared_o(shared_o),
    .wb_o(wb_o), .line_state_o(line_state_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at negedge; outputs captured before the next rising edge
  task automatic step(input logic [1:0] cop, input int cidx, input logic [1:0] sop,
                      input int sidx, input logic sh);
    cpu_op = cop; cpu_idx = IDX_W'(cidx); snp_op = sop; snp_idx = IDX_W'(sidx);
    shared_in = sh;
    #1;
    o_bus = bus_req_o; o_sup = supply_o; o_shr = shared_o; o_wb = wb_o;
    @(negedge clk);
    cpu_op = 2'd0; snp_op = 2'd0; shared_in = 1'b0;
  endtask

  task automatic peek(input int idx, output int st);
    cpu_op = 2'd0; cpu_idx = IDX_W'(idx);
    #1;
    st = int'(line_state_o);
    @(negedge clk);
  endtask

  // I=0 S=1 E=2 F=3 M=4
  task automatic set_state(input int idx, input int s);
    step(2'd3, idx, 2'd0, 0, 1'b0);
    case (s)
      1: begin step(2'd1, idx, 2'd0, 0, 1'b1); step(2'd0, 0, 2'd1, idx, 1'b0); end
      2: step(2'd1, idx, 2'd0, 0, 1'b0);
      3: step(2'd1, idx, 2'd0, 0, 1'b1);
      4: step(2'd2, idx, 2'd0, 0, 1'b0);
      default: ;
    endcase
  endtask

  function automatic string snp_tag(input int s, input int op);
    if (op != 1) return "R8 snoop kill";
    if (s == 4) return "R4 snoop read M";
    if (s == 2 || s == 3) return "R3 snoop read owner";
    return "R5 snoop read S/I";
  endfunction

  function automatic string cpu_tag(input int s, input int op);
    if (op == 1) return "R2 cpu read";
    if (op == 3) return "R9 cpu evict";
    if (s == 0) return "R7 write miss";
    return "R6 write hit";
  endfunction

  initial begin
    int st;
    repeat (3) @(negedge clk);
    for (int i = 0; i < N; i++) begin
      cpu_idx = IDX_W'(i); #0.5;
      chk("R1 reset state", int'(line_state_o), 0);
    end
    rst_ni = 1'b1;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      peek(i, st);
      chk("R1 after reset", st, 0);
    end

    // snoop sweep
    for (int s = 0; s < 5; s++) begin
      for (int op = 1; op < 4; op++) begin
        int idx = (s + op) % N;
        int e_nxt, e_sup, e_shr, e_wb;
        set_state(idx, s);
        step(2'd0, 0, 2'(op), idx, 1'b0);
        if (op == 1) begin
          e_nxt = (s == 0) ? 0 : 1;
          e_sup = (s >= 2) ? 1 : 0;
          e_shr = (s != 0) ? 1 : 0;
          e_wb  = (s == 4) ? 1 : 0;
        end else begin
          e_nxt = 0;
          e_sup = (op == 2 && s == 4) ? 1 : 0;
          e_shr = 0;
          e_wb  = 0;
        end
        chk({snp_tag(s, op), " supply"}, int'(o_sup), e_sup);
        chk({snp_tag(s, op), " shared"}, int'(o_shr), e_shr);
        chk({snp_tag(s, op), " wb"}, int'(o_wb), e_wb);
        chk({snp_tag(s, op), " bus"}, int'(o_bus), 0);
        peek(idx, st);
        chk({snp_tag(s, op), " state"}, st, e_nxt);
      end
    end

    // processor sweep
    for (int s = 0; s < 5; s++) begin
      for (int op = 1; op < 4; op++) begin
        for (int sh = 0; sh < 2; sh++) begin
          int idx = (s * 3 + op + sh) % N;
          int e_nxt, e_bus, e_wb;
          set_state(idx, s);
          step(2'(op), idx, 2'd0, 0, 1'(sh));
          e_wb = 0; e_bus = 0; e_nxt = s;
          if (op == 1) begin
            if (s == 0) begin e_bus = 1; e_nxt = sh ? 3 : 2; end
          end else if (op == 2) begin
            e_nxt = 4;
            if (s == 0) e_bus = 2;
            else if (s == 1 || s == 3) e_bus = 3;
          end else begin
            e_nxt = 0;
            e_wb = (s == 4) ? 1 : 0;
          end
          chk({cpu_tag(s, op), " bus"}, int'(o_bus), e_bus);
          chk({cpu_tag(s, op), " wb"}, int'(o_wb), e_wb);
          chk({cpu_tag(s, op), " supply"}, int'(o_sup), 0);
          peek(idx, st);
          chk({cpu_tag(s, op), " state"}, st, e_nxt);
        end
      end
    end

    // R10 same-index: snoop rwitm kills S, write then misses
    set_state(5, 1);
    step(2'd2, 5, 2'd2, 5, 1'b0);
    chk("R10 collide write bus", int'(o_bus), 2);
    peek(5, st);
    chk("R10 collide write state", st, 4);
    // R10 same-index: snoop read on F, cpu read hits demoted S
    set_state(6, 3);
    step(2'd1, 6, 2'd1, 6, 1'b0);
    chk("R10 collide read bus", int'(o_bus), 0);
    chk("R10 collide read supply", int'(o_sup), 1);
    peek(6, st);
    chk("R10 collide read state", st, 1);
    // R10 same-index: invalidate on E, cpu read becomes miss
    set_state(7, 2);
    step(2'd1, 7, 2'd3, 7, 1'b1);
    chk("R10 collide inv read bus", int'(o_bus), 1);
    peek(7, st);
    chk("R10 collide inv read state", st, 3);
    // R10 different indices both apply
    set_state(1, 1);
    set_state(2, 2);
    step(2'd2, 2, 2'd3, 1, 1'b0);
    chk("R10 split bus", int'(o_bus), 0);
    peek(1, st);
    chk("R10 split snoop state", st, 0);
    peek(2, st);
    chk("R10 split cpu state", st, 4);
    // R3 ownership re-established by next reader after F lost
    set_state(3, 1);
    step(2'd3, 3, 2'd0, 0, 1'b0);
    step(2'd1, 3, 2'd0, 0, 1'b1);
    peek(3, st);
    chk("R3 forward regained by reader", st, 3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule